// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block is a performance-monitoring counter bank for one cache slice. It holds eight 32-bit event counters. Each counter picks the event it counts through an 8-bit selector. Software reaches everything through one word-wide register port: a global control word, set and clear registers for the count-enable mask and the interrupt-enable mask, a write-one-to-clear overflow status, a pairing mask and a per-counter "early overflow" mode.

Any even counter and the odd counter above it can be joined into a single 64-bit counter. The odd half then advances on every wrap of the even half and no longer counts an event of its own. A counter whose overflow status bit is set and whose interrupt is enabled drives the single level-sensitive interrupt output.

The register port is a plain control interface with no handshake. A write takes effect at the clock edge on which `reg_wr` is high. `reg_rdata` shows, combinationally, the register addressed by `reg_addr`. Event inputs are single-cycle strobes that are sampled on every clock.

Top module: `evt_ctr_bank`

## Requirements
- R1: Counter n sits at byte address 0x420+8n and its event selector at 0x220+8n (low 8 bits). Selector 0x00 never counts, 0x01 counts every cycle, and any other code c below the number of event lines counts when `evt_in[c]` is high. A counter advances by one in a cycle only when the master enable, its own enable bit and its selected event are all high.
- R2: A write to 0x508 sets the count-enable bits that are 1 in the data. A write to 0x50C clears them. Zero bits change nothing, and reading either address returns the current mask.
- R3: The interrupt-enable mask follows the same set/clear rules at 0x510 (set) and 0x514 (clear), and both addresses read back the mask.
- R4: At 0x718, bit k for odd k pairs counter k with counter k-1. A paired odd counter then advances only on a cycle where counter k-1 wraps from all-ones to zero, and it ignores its own selector and events. Even bits of 0x718 are not stored and read 0.
- R5: The overflow status at 0x740 holds one bit per counter, set when that counter overflows. Writing 1s clears the matching bits. An overflow in the same cycle as a clearing write leaves the bit set.
- R6: When bit n of 0x96C is set, counter n reports overflow on the step from 0x7FFFFFFF to 0x80000000 instead of on the wrap to zero.
- R7: `irq_o` is high exactly when some counter has both its overflow status bit and its interrupt-enable bit set.
- R8: Bit 0 of the control word at 0x500 is the master enable and reads back. Writing 1 to bit 1 clears every counter to zero; that bit always reads 0.
- R9: A software write to a counter wins over an increment in the same cycle, and a counter that is written does not carry into its partner in that cycle.
- R10: After reset every counter, selector, mask, status bit and the master enable read 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 64 | Event strobes, one per selector code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a 64-bit pair crossing its lower-half wrap. The same goes for the early-overflow step, which sits 2^31 events away from reset. The bench reaches both by loading counters through the register port with values a few counts below 0xFFFFFFFF or 0x7FFFFFFF, then letting the cycle-count selector or random event strobes carry them across. A directed case also writes the even half on the very cycle it would wrap, so that a carry into the odd half must not occur.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CTRL     = 12'h500;
  localparam logic [ADDR_W-1:0] A_ENSET    = 12'h508;
  localparam logic [ADDR_W-1:0] A_ENCLR    = 12'h50C;
  localparam logic [ADDR_W-1:0] A_IESET    = 12'h510;
  localparam logic [ADDR_W-1:0] A_IECLR    = 12'h514;
  localparam logic [ADDR_W-1:0] A_PAIR     = 12'h718;
  localparam logic [ADDR_W-1:0] A_OVS      = 12'h740;
  localparam logic [ADDR_W-1:0] A_EARLY    = 12'h96C;
  localparam logic [ADDR_W-1:0] A_SEL_BASE = 12'h220;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 12'h420;
  localparam int                STRIDE     = 8;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;

  localparam int SEL_NONE   = 0;
  localparam int SEL_CYCLES = 1;
endpackage

// File: rtl/ecb_counter.sv
module ecb_counter
  import ecb_pkg::*;
#(
  parameter int CTR_W   = 32,
  parameter int SEL_W   = 8,
  parameter int NUM_EVT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               cnt_en,
  input  logic               clr_all,
  input  logic               wr_cnt,
  input  logic               wr_sel,
  input  logic [CTR_W-1:0]   wdata,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               chain_sel,
  input  logic               carry_in,
  input  logic               early_mode,
  output logic [CTR_W-1:0]   cnt_q,
  output logic [SEL_W-1:0]   sel_q,
  output logic               carry_out,
  output logic               ovf_pulse
);
  localparam int IDX_W = $clog2(NUM_EVT);
  localparam logic [CTR_W-1:0] HALF_MAX = {1'b0, {(CTR_W-1){1'b1}}};

  logic evt_hit, inc, take;

  always_comb begin
    if (int'(sel_q) == SEL_NONE)        evt_hit = 1'b0;
    else if (int'(sel_q) == SEL_CYCLES) evt_hit = 1'b1;
    else if (int'(sel_q) < NUM_EVT)     evt_hit = evt_in[sel_q[IDX_W-1:0]];
    else                                evt_hit = 1'b0;
  end

  assign inc       = run & cnt_en & (chain_sel ? carry_in : evt_hit);
  assign take      = inc & ~clr_all & ~wr_cnt;
  assign carry_out = take & (&cnt_q);
  assign ovf_pulse = take & (early_mode ? (cnt_q == HALF_MAX) : (&cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_all) cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= wdata;
    else if (take)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= wdata[SEL_W-1:0];
  end

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |=> (cnt_q == '0));
  // R9
  sw_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !clr_all) |=> (cnt_q == $past(wdata)));
  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (cnt_q == '0));
endmodule

// File: rtl/ecb_ctrl.sv
module ecb_ctrl
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_CTR-1:0] wmask,
  input  logic [NUM_CTR-1:0] ovf_in,
  output logic               run,
  output logic               clr_all,
  output logic [NUM_CTR-1:0] en_q,
  output logic [NUM_CTR-1:0] ie_q,
  output logic [NUM_CTR-1:0] pair_q,
  output logic [NUM_CTR-1:0] early_q,
  output logic [NUM_CTR-1:0] ovs_q,
  output logic               irq_o
);
  logic [NUM_CTR-1:0] odd_mask;
  logic [NUM_CTR-1:0] ovs_clr;

  always_comb
    for (int i = 0; i < NUM_CTR; i++) odd_mask[i] = (i % 2) == 1;

  assign clr_all = reg_wr && (reg_addr == A_CTRL) && wmask[CTRL_CLR_BIT];
  assign ovs_clr = (reg_wr && reg_addr == A_OVS) ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      en_q    <= '0;
      ie_q    <= '0;
      pair_q  <= '0;
      early_q <= '0;
      ovs_q   <= '0;
    end else begin
      ovs_q <= (ovs_q & ~ovs_clr) | ovf_in;
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL:  run     <= wmask[CTRL_RUN_BIT];
          A_ENSET: en_q    <= en_q | wmask;
          A_ENCLR: en_q    <= en_q & ~wmask;
          A_IESET: ie_q    <= ie_q | wmask;
          A_IECLR: ie_q    <= ie_q & ~wmask;
          A_PAIR:  pair_q  <= wmask & odd_mask;
          A_EARLY: early_q <= wmask;
          default: ;
        endcase
      end
    end
  end

  assign irq_o = |(ovs_q & ie_q);

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ENSET) |=> ((en_q & $past(wmask)) == $past(wmask)));
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ENCLR) |=> ((en_q & $past(wmask)) == '0));
  // R5
  ovs_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_in) |=> ((ovs_q & $past(ovf_in)) == $past(ovf_in)));
  // R8
  run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL) |=> (run == $past(wmask[CTRL_RUN_BIT])));
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 32,
  parameter int SEL_W   = 8,
  parameter int NUM_EVT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CTR_W-1:0]   reg_wdata,
  output logic [CTR_W-1:0]   reg_rdata,
  output logic               irq_o
);
  logic               run, clr_all;
  logic [NUM_CTR-1:0] en_q, ie_q, pair_q, early_q, ovs_q;
  logic [NUM_CTR-1:0] ovf, carry, wr_cnt, wr_sel;
  logic [CTR_W-1:0]   cnt   [NUM_CTR];
  logic [SEL_W-1:0]   sel   [NUM_CTR];
  logic               unused_last_carry;

  assign unused_last_carry = carry[NUM_CTR-1];

  ecb_ctrl #(.NUM_CTR(NUM_CTR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wmask(reg_wdata[NUM_CTR-1:0]), .ovf_in(ovf), .run(run), .clr_all(clr_all),
    .en_q(en_q), .ie_q(ie_q), .pair_q(pair_q), .early_q(early_q),
    .ovs_q(ovs_q), .irq_o(irq_o)
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    localparam logic [ADDR_W-1:0] CNT_A = A_CNT_BASE + ADDR_W'(STRIDE * n);
    localparam logic [ADDR_W-1:0] SEL_A = A_SEL_BASE + ADDR_W'(STRIDE * n);
    logic cin;

    assign wr_cnt[n] = reg_wr && (reg_addr == CNT_A);
    assign wr_sel[n] = reg_wr && (reg_addr == SEL_A);

    if (n == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_rest
      assign cin = carry[n-1];
    end

    ecb_counter #(.CTR_W(CTR_W), .SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt_en(en_q[n]), .clr_all(clr_all),
      .wr_cnt(wr_cnt[n]), .wr_sel(wr_sel[n]), .wdata(reg_wdata), .evt_in(evt_in),
      .chain_sel(pair_q[n]), .carry_in(cin), .early_mode(early_q[n]),
      .cnt_q(cnt[n]), .sel_q(sel[n]), .carry_out(carry[n]), .ovf_pulse(ovf[n])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:           reg_rdata[CTRL_RUN_BIT] = run;
      A_ENSET, A_ENCLR: reg_rdata = CTR_W'(en_q);
      A_IESET, A_IECLR: reg_rdata = CTR_W'(ie_q);
      A_PAIR:           reg_rdata = CTR_W'(pair_q);
      A_OVS:            reg_rdata = CTR_W'(ovs_q);
      A_EARLY:          reg_rdata = CTR_W'(early_q);
      default: begin
        for (int n = 0; n < NUM_CTR; n++) begin
          if (reg_addr == A_CNT_BASE + ADDR_W'(STRIDE * n)) reg_rdata = cnt[n];
          if (reg_addr == A_SEL_BASE + ADDR_W'(STRIDE * n)) reg_rdata = CTR_W'(sel[n]);
        end
      end
    endcase
  end

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((ovs_q & ie_q) != '0));
endmodule

// File: tb/evt_ctr_bank_bench.sv
module evt_ctr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt_in = '0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_cnt [8];
  logic [7:0]  m_sel [8];
  logic [7:0]  m_en, m_ie, m_pair, m_early, m_ovs;
  logic        m_run;

  always #4 clk = ~clk;

  evt_ctr_bank u_evt_ctr_bank (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] cnt_a(input int n); return 12'h420 + 12'(8 * n); endfunction
  function automatic logic [11:0] sel_a(input int n); return 12'h220 + 12'(8 * n); endfunction

  function automatic logic [11:0] pick_addr(input int k);
    case (k)
      0: return 12'h500;  1: return 12'h508;  2: return 12'h50C;
      3: return 12'h510;  4: return 12'h514;  5: return 12'h718;
      6: return 12'h740;  7: return 12'h96C;
      default: return (k < 16) ? cnt_a(k - 8) : sel_a(k - 16);
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    case (a)
      12'h500: return "R8";
      12'h508, 12'h50C: return "R2";
      12'h510, 12'h514: return "R3";
      12'h718: return "R4";
      12'h740: return "R5";
      12'h96C: return "R6";
      default: return (a >= 12'h420) ? "R1_R9" : "R1";
    endcase
  endfunction

  function automatic logic [31:0] model_rd(input logic [11:0] a);
    case (a)
      12'h500: return {31'd0, m_run};
      12'h508, 12'h50C: return {24'd0, m_en};
      12'h510, 12'h514: return {24'd0, m_ie};
      12'h718: return {24'd0, m_pair};
      12'h740: return {24'd0, m_ovs};
      12'h96C: return {24'd0, m_early};
      default: begin
        for (int n = 0; n < 8; n++) begin
          if (a == cnt_a(n)) return m_cnt[n];
          if (a == sel_a(n)) return {24'd0, m_sel[n]};
        end
        return 32'd0;
      end
    endcase
  endfunction

  function automatic logic ev_hit(input logic [7:0] s, input logic [63:0] e);
    if (s == 8'd0) return 1'b0;
    if (s == 8'd1) return 1'b1;
    if (s < 8'd64) return e[s[5:0]];
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int n = 0; n < 8; n++) begin m_cnt[n] = '0; m_sel[n] = '0; end
    m_en = '0; m_ie = '0; m_pair = '0; m_early = '0; m_ovs = '0; m_run = 1'b0;
  endtask

  task automatic model_step(input logic w, input logic [11:0] a, input logic [31:0] d,
                            input logic [63:0] e);
    logic [7:0] cy, ov;
    logic [31:0] nxt [8];
    logic clr;
    clr = w && a == 12'h500 && d[1];
    cy = '0; ov = '0;
    for (int n = 0; n < 8; n++) begin
      logic hit, take, wr;
      hit  = (m_pair[n] && n > 0) ? cy[(n > 0) ? n - 1 : 0] : ev_hit(m_sel[n], e);
      wr   = w && a == cnt_a(n);
      take = m_run && m_en[n] && hit && !clr && !wr;
      cy[n] = take && m_cnt[n] == 32'hFFFF_FFFF;
      ov[n] = take && (m_early[n] ? m_cnt[n] == 32'h7FFF_FFFF : m_cnt[n] == 32'hFFFF_FFFF);
      nxt[n] = clr ? 32'd0 : wr ? d : take ? m_cnt[n] + 32'd1 : m_cnt[n];
      if (w && a == sel_a(n)) m_sel[n] = d[7:0];
    end
    for (int n = 0; n < 8; n++) m_cnt[n] = nxt[n];
    m_ovs = (m_ovs & ~((w && a == 12'h740) ? d[7:0] : 8'd0)) | ov;
    if (w) case (a)
      12'h500: m_run = d[0];
      12'h508: m_en = m_en | d[7:0];
      12'h50C: m_en = m_en & ~d[7:0];
      12'h510: m_ie = m_ie | d[7:0];
      12'h514: m_ie = m_ie & ~d[7:0];
      12'h718: m_pair = d[7:0] & 8'hAA;
      12'h96C: m_early = d[7:0];
      default: ;
    endcase
  endtask

  task automatic cyc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic [63:0] e);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; evt_in = e;
    #1;
    if (!w) check(req_of(a), reg_rdata, model_rd(a));
    check("R7", {31'd0, irq_o}, {31'd0, |(m_ovs & m_ie)});
    @(posedge clk);
    model_step(w, a, d, e);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, '0);
  endtask

  task automatic rd(input logic [11:0] a);
    cyc(1'b0, a, '0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10: everything reads zero after reset
    for (int k = 0; k < 24; k++) begin
      @(negedge clk); reg_addr = pick_addr(k); #1;
      check("R10", reg_rdata, 32'd0);
    end
    check("R10", {31'd0, irq_o}, 32'd0);

    // R4 / R9: chained pair 0/1 across the lower wrap, cycles selector
    wr(sel_a(0), 32'h01);
    wr(sel_a(1), 32'h00);
    wr(12'h718, 32'hFF);          // even bits dropped (R4)
    rd(12'h718);
    wr(cnt_a(0), 32'hFFFF_FFFD);
    wr(cnt_a(1), 32'h0000_0005);
    wr(12'h508, 32'h03);
    wr(12'h510, 32'h01);
    wr(12'h500, 32'h1);
    rd(cnt_a(0)); rd(cnt_a(1)); rd(cnt_a(0)); rd(cnt_a(1)); rd(12'h740);
    // R9: write even half on its wrap cycle, no carry
    wr(cnt_a(0), 32'hFFFF_FFFF);
    wr(cnt_a(0), 32'h1234_0000);
    rd(cnt_a(1));
    // R5: clear status
    wr(12'h740, 32'hFF);
    rd(12'h740);
    // R6: early overflow on counter 2
    wr(sel_a(2), 32'h01);
    wr(12'h96C, 32'h04);
    wr(cnt_a(2), 32'h7FFF_FFFE);
    wr(12'h508, 32'h04);
    rd(12'h740); rd(cnt_a(2)); rd(12'h740);
    // R8: clear all counters
    wr(12'h500, 32'h3);
    rd(cnt_a(0)); rd(cnt_a(2));
    wr(12'h50C, 32'h02);
    rd(12'h508);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      int r, k;
      logic [11:0] a;
      logic [31:0] d;
      logic [63:0] e;
      r = $urandom_range(0, 99);
      k = $urandom_range(0, 23);
      a = pick_addr(k);
      e = {$urandom, $urandom};
      d = $urandom;
      if (k >= 8 && k < 16) d = (r % 2) ? 32'hFFFF_FFF0 | (d & 32'hF) : 32'h7FFF_FFF8 | (d & 32'h7);
      if (k >= 16) d = (r % 3 == 0) ? 32'h1 : (r % 3 == 1) ? 32'h0 : {26'd0, d[5:0]};
      if (k == 0) d = (r % 8 == 0) ? 32'h3 : 32'h1;
      if (r < 35) cyc(1'b1, a, d, e);
      else        cyc(1'b0, a, '0, e);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule